// File: doc/BRIEF.md
# AES Encryption Round with Byte-Parity Error Detection

This block performs one AES-128 encryption round (byte substitution, row rotation, column mixing and round-key addition) on a 128-bit state. Alongside the data it carries one parity bit for every state byte and for every round-key byte. At each step it predicts the parity that the result should have, using only the incoming parity bits and a few data bits. It does not derive the check bits again from the result. At the end it derives parity from the bytes actually produced and raises an error flag wherever the two disagree. A single upset in the datapath, the state register or the key therefore shows up as a mismatch at the round output.

The substitution stage works on 9 bits in and 9 bits out. When a byte arrives with inconsistent parity, it emits a deliberately inverted output parity instead of flagging the error locally. An error from an earlier round is therefore carried forward and caught by the single comparison at the output. A last-round input removes column mixing from both the data path and the parity prediction. With the default configuration, all outputs are captured in registers when a valid strobe is high and held otherwise. A parameter turns the block into a purely combinational one.

Top module: `aes_round_ced`

## Requirements
- R1: With the last-round input low, the output state is the key added to the column mix of the row-rotated S-box substitution of the input state. Byte k (0..15) occupies bits 127-8k down to 120-8k, sits in row k mod 4 and column k/4, and output row r, column c takes the substituted byte from row r, column (c+r) mod 4.
- R2: With the last-round input high, column mixing is skipped, so the output is the key added to the row-rotated substitution.
- R3: Generated parity bit 15-k is the XOR of the 8 bits of output byte k (even parity).
- R4: When every state and key parity bit matches its byte (bit 15-k belongs to byte k), the predicted parity equals the generated parity and the error flag is 0, in both round kinds.
- R5: A state byte whose parity bit is wrong makes the S-box emit inverted parity, so the error propagates. In a last round exactly 1 predicted bit differs from the generated one. In a full round exactly 3 bits of the affected column differ. The error flag is 1 in both cases.
- R6: A single round-key byte with a wrong parity bit makes exactly one predicted bit differ, at that byte's position, and sets the error flag.
- R7: Flipping two bits inside one state byte while keeping its parity bit is not detected. The error flag stays 0, while the output follows the altered data.
- R8: With registered outputs, the outputs and the valid output update one clock after a valid input. Without a valid input the outputs hold and the valid output is 0. Reset clears all outputs.
- R9: The error flag is 1 exactly when the predicted and generated parity vectors differ in any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Capture strobe for the output registers |
| state_in | input | 128 | Round input state |
| state_par_in | input | 16 | Parity bits of the state bytes |
| rkey_in | input | 128 | Round key |
| rkey_par_in | input | 16 | Parity bits of the key bytes |
| final_rnd | input | 1 | Last round: bypass column mixing |
| valid_out | output | 1 | Outputs updated this cycle |
| state_out | output | 128 | New state |
| par_pred | output | 16 | Predicted parity vector |
| par_gen | output | 16 | Parity generated from state_out |
| err | output | 1 | Predicted and generated parity differ |

## Verification
The round is first driven with all-zero and all-0x53 states in a last round with a zero key, which exposes known S-box values directly. Pseudo-random states and keys with consistent parity follow in both round kinds, separating the row-rotation and column-mix data paths and the bypass. Single wrong parity bits are then placed on different state bytes and key bytes. Here the number and position of mismatching bits tell whether the error went through the S-box inversion and the column-mix prediction or only through key addition. A two-bit flip within one byte and cycles without a strobe show the parity limit and the register hold behaviour.

// File: rtl/aes_ced_pkg.sv
package aes_ced_pkg;
   typedef logic [7:0] byte_t;

   localparam byte_t AES_POLY_LO = 8'h1b;
   localparam byte_t AES_AFFINE_C = 8'h63;

   function automatic byte_t xtime(input byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? AES_POLY_LO : 8'h00);
   endfunction

   function automatic byte_t gmul(input byte_t a, input byte_t b);
      byte_t acc;
      byte_t sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = xtime(sh);
      end
      return acc;
   endfunction

   function automatic byte_t rotl(input byte_t a, input int n);
      return byte_t'((a << n) | (a >> (8 - n)));
   endfunction
endpackage

// File: rtl/aes_sbox_par.sv
module aes_sbox_par
   import aes_ced_pkg::*;
(
   input  byte_t din,
   input  logic  pin,
   output byte_t dout,
   output logic  pout
);
   function automatic byte_t gf_inv(input byte_t x);
      byte_t sq;
      byte_t acc;
      sq  = x;
      acc = 8'h01;
      for (int i = 1; i < 8; i++) begin
         sq  = gmul(sq, sq);
         acc = gmul(acc, sq);
      end
      return acc;
   endfunction

   byte_t inv_b;
   logic  in_bad;

   always_comb begin
      inv_b  = gf_inv(din);
      dout   = inv_b ^ rotl(inv_b, 1) ^ rotl(inv_b, 2) ^ rotl(inv_b, 3)
               ^ rotl(inv_b, 4) ^ AES_AFFINE_C;
      in_bad = (^din) ^ pin;
      pout   = (^dout) ^ in_bad;
   end
endmodule

// File: rtl/aes_mixcol_par.sv
module aes_mixcol_par
   import aes_ced_pkg::*;
#(
   parameter int N_ROWS = 4
)(
   input  logic [N_ROWS-1:0][7:0] col_in,
   input  logic [N_ROWS-1:0]      par_in,
   output logic [N_ROWS-1:0][7:0] col_out,
   output logic [N_ROWS-1:0]      par_out
);
   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      localparam int NX1 = (r + 1) % N_ROWS;
      localparam int NX2 = (r + 2) % N_ROWS;
      localparam int NX3 = (r + 3) % N_ROWS;
      always_comb begin
         col_out[r] = xtime(col_in[r]) ^ xtime(col_in[NX1]) ^ col_in[NX1]
                      ^ col_in[NX2] ^ col_in[NX3];
         // parity of 2a is p(a)^msb(a); parity of 3a is msb(a)
         par_out[r] = par_in[r] ^ par_in[NX2] ^ par_in[NX3]
                      ^ col_in[r][7] ^ col_in[NX1][7];
      end
   end
endmodule

// File: rtl/aes_round_ced.sv
module aes_round_ced
   import aes_ced_pkg::*;
#(
   parameter int N_ROWS  = 4,
   parameter int N_COLS  = 4,
   parameter int BYTE_W  = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int NB      = N_ROWS * N_COLS,
   localparam int STATE_W = NB * BYTE_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_in,
   input  logic [STATE_W-1:0] state_in,
   input  logic [NB-1:0]      state_par_in,
   input  logic [STATE_W-1:0] rkey_in,
   input  logic [NB-1:0]      rkey_par_in,
   input  logic               final_rnd,
   output logic               valid_out,
   output logic [STATE_W-1:0] state_out,
   output logic [NB-1:0]      par_pred,
   output logic [NB-1:0]      par_gen,
   output logic               err
);
   if (N_ROWS != 4) begin : g_bad_rows
      $error("aes_round_ced: N_ROWS must be 4");
   end
   if (N_COLS != 4) begin : g_bad_cols
      $error("aes_round_ced: N_COLS must be 4");
   end
   if (BYTE_W != 8) begin : g_bad_width
      $error("aes_round_ced: BYTE_W must be 8");
   end

   logic [NB-1:0][7:0] s_b, sb_b, sr_b, mc_b, mx_b, ak_b, k_b;
   logic [NB-1:0]      s_p, sb_p, sr_p, mc_p, mx_p, ak_p, k_p;
   logic [STATE_W-1:0] nxt_state;
   logic [NB-1:0]      nxt_pred, nxt_gen;
   logic               nxt_err;

   for (genvar k = 0; k < NB; k++) begin : g_byte
      localparam int ROW = k % N_ROWS;
      localparam int COL = k / N_ROWS;
      localparam int SRC = ROW + N_ROWS * ((COL + ROW) % N_COLS);

      assign s_b[k] = state_in[STATE_W-1-BYTE_W*k -: BYTE_W];
      assign s_p[k] = state_par_in[NB-1-k];
      assign k_b[k] = rkey_in[STATE_W-1-BYTE_W*k -: BYTE_W];
      assign k_p[k] = rkey_par_in[NB-1-k];

      aes_sbox_par u_sbox (
         .din  (s_b[k]),
         .pin  (s_p[k]),
         .dout (sb_b[k]),
         .pout (sb_p[k])
      );

      // row rotation moves data and parity together
      assign sr_b[k] = sb_b[SRC];
      assign sr_p[k] = sb_p[SRC];

      assign mx_b[k] = final_rnd ? sr_b[k] : mc_b[k];
      assign mx_p[k] = final_rnd ? sr_p[k] : mc_p[k];

      assign ak_b[k] = mx_b[k] ^ k_b[k];
      assign ak_p[k] = mx_p[k] ^ k_p[k];

      assign nxt_state[STATE_W-1-BYTE_W*k -: BYTE_W] = ak_b[k];
      assign nxt_pred[NB-1-k] = ak_p[k];
      assign nxt_gen[NB-1-k]  = ^ak_b[k];
   end

   for (genvar c = 0; c < N_COLS; c++) begin : g_col
      aes_mixcol_par #(.N_ROWS(N_ROWS)) u_mix (
         .col_in  (sr_b[N_ROWS*c +: N_ROWS]),
         .par_in  (sr_p[N_ROWS*c +: N_ROWS]),
         .col_out (mc_b[N_ROWS*c +: N_ROWS]),
         .par_out (mc_p[N_ROWS*c +: N_ROWS])
      );
   end

   assign nxt_err = |(nxt_pred ^ nxt_gen);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_out <= 1'b0;
            state_out <= '0;
            par_pred  <= '0;
            par_gen   <= '0;
            err       <= 1'b0;
         end else begin
            valid_out <= valid_in;
            if (valid_in) begin
               state_out <= nxt_state;
               par_pred  <= nxt_pred;
               par_gen   <= nxt_gen;
               err       <= nxt_err;
            end
         end
      end
   end else begin : g_comb
      assign valid_out = valid_in;
      assign state_out = nxt_state;
      assign par_pred  = nxt_pred;
      assign par_gen   = nxt_gen;
      assign err       = nxt_err;
   end
endmodule

// File: rtl/aes_round_ced_chk.sv
module aes_round_ced_chk #(
   parameter int NB      = 16,
   parameter bit REG_OUT = 1'b1,
   localparam int STATE_W = NB * 8
)(
   input logic               clk,
   input logic               rst_n,
   input logic               valid_in,
   input logic [STATE_W-1:0] state_in,
   input logic [NB-1:0]      state_par_in,
   input logic [STATE_W-1:0] rkey_in,
   input logic [NB-1:0]      rkey_par_in,
   input logic               valid_out,
   input logic [STATE_W-1:0] state_out,
   input logic [NB-1:0]      par_pred,
   input logic [NB-1:0]      par_gen,
   input logic               err
);
   logic [NB-1:0] s_bad, k_bad;

   always_comb begin
      for (int k = 0; k < NB; k++) begin
         s_bad[NB-1-k] = (^state_in[STATE_W-1-8*k -: 8]) ^ state_par_in[NB-1-k];
         k_bad[NB-1-k] = (^rkey_in[STATE_W-1-8*k -: 8]) ^ rkey_par_in[NB-1-k];
      end
   end

   if (REG_OUT) begin : g_seq
      assert_clean_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && s_bad == '0 && k_bad == '0) |=> !err);

      assert_state_err_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && $countones(s_bad) == 1 && k_bad == '0) |=> err);

      assert_key_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && s_bad == '0 && $countones(k_bad) == 1)
         |=> $countones(par_pred ^ par_gen) == 1);

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> (!valid_out && $stable(state_out) && $stable(err)
                        && $stable(par_pred)));

      assert_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> valid_out);

      assert_err_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
         err == (par_pred != par_gen));
   end
endmodule

bind aes_round_ced aes_round_ced_chk #(.NB(NB), .REG_OUT(REG_OUT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .valid_in     (valid_in),
   .state_in     (state_in),
   .state_par_in (state_par_in),
   .rkey_in      (rkey_in),
   .rkey_par_in  (rkey_par_in),
   .valid_out    (valid_out),
   .state_out    (state_out),
   .par_pred     (par_pred),
   .par_gen      (par_gen),
   .err          (err)
);

// File: tb/aes_round_ced_tb.sv
module aes_round_ced_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_in = 1'b0;
   logic [127:0] state_in = '0;
   logic [15:0]  state_par_in = '0;
   logic [127:0] rkey_in = '0;
   logic [15:0]  rkey_par_in = '0;
   logic         final_rnd = 1'b0;
   logic         valid_out;
   logic [127:0] state_out;
   logic [15:0]  par_pred, par_gen;
   logic         err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk = ~clk;

   aes_round_ced u_dut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .state_in(state_in),
      .state_par_in(state_par_in), .rkey_in(rkey_in), .rkey_par_in(rkey_par_in),
      .final_rnd(final_rnd), .valid_out(valid_out), .state_out(state_out),
      .par_pred(par_pred), .par_gen(par_gen), .err(err)
   );

   // ---------------- reference model ----------------
   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r = 8'h00;
      logic [7:0] x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r ^= x;
         x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] m_sbox(input logic [7:0] x);
      logic [7:0] inv = 8'h00;
      logic [7:0] c = 8'h63;
      logic [7:0] o;
      if (x != 8'h00)
         for (int b = 1; b < 256; b++)
            if (m_mul(x, 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
         o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
      return o;
   endfunction

   function automatic logic [7:0] gb(input logic [127:0] v, input int k);
      return v[127-8*k -: 8];
   endfunction

   function automatic logic [15:0] m_par(input logic [127:0] v);
      logic [15:0] p;
      for (int k = 0; k < 16; k++) p[15-k] = ^gb(v, k);
      return p;
   endfunction

   function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] key,
                                            input logic last);
      logic [7:0] sb [16];
      logic [7:0] sr [16];
      logic [7:0] mc [16];
      logic [127:0] o;
      for (int k = 0; k < 16; k++) sb[k] = m_sbox(gb(s, k));
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) sr[r+4*c] = sb[r+4*((c+r)%4)];
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            mc[r+4*c] = m_mul(8'h02, sr[r+4*c]) ^ m_mul(8'h03, sr[(r+1)%4+4*c])
                        ^ sr[(r+2)%4+4*c] ^ sr[(r+3)%4+4*c];
      for (int k = 0; k < 16; k++)
         o[127-8*k -: 8] = (last ? sr[k] : mc[k]) ^ gb(key, k);
      return o;
   endfunction

   // prediction = true parity of result with input parity errors carried linearly
   function automatic logic [15:0] m_pred(input logic [127:0] s, input logic [15:0] sp,
                                          input logic [127:0] key, input logic [15:0] kp,
                                          input logic last);
      logic ei [16];
      logic es [16];
      logic eo [16];
      logic [15:0] p;
      for (int k = 0; k < 16; k++) ei[k] = (^gb(s, k)) ^ sp[15-k];
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) es[r+4*c] = ei[r+4*((c+r)%4)];
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            eo[r+4*c] = last ? es[r+4*c]
                        : es[r+4*c] ^ es[(r+2)%4+4*c] ^ es[(r+3)%4+4*c];
      p = m_par(m_round(s, key, last));
      for (int k = 0; k < 16; k++) p[15-k] ^= eo[k] ^ (^gb(key, k)) ^ kp[15-k];
      return p;
   endfunction

   function automatic logic [127:0] rnd128();
      logic [127:0] v;
      for (int i = 0; i < 4; i++) begin
         seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
         v[32*i +: 32] = seed;
      end
      return v;
   endfunction

   // ---------------- checking helpers ----------------
   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [127:0] s, input logic [15:0] sp,
                        input logic [127:0] key, input logic [15:0] kp, input logic last);
      @(negedge clk);
      state_in = s; state_par_in = sp; rkey_in = key; rkey_par_in = kp;
      final_rnd = last; valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   task automatic run_round(input string req, input logic [127:0] s, input logic [15:0] sp,
                            input logic [127:0] key, input logic [15:0] kp, input logic last);
      logic [127:0] eo;
      logic [15:0]  ep, eg;
      apply(s, sp, key, kp, last);
      eo = m_round(s, key, last);
      eg = m_par(eo);
      ep = m_pred(s, sp, key, kp, last);
      chk(req, "state_out", state_out, eo);
      chk("R3", "par_gen", par_gen, eg);
      chk(req, "par_pred", par_pred, ep);
      chk("R9", "err", err, ep != eg);
      chk("R8", "valid_out", valid_out, 1'b1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8", "reset valid_out", valid_out, 1'b0);
      chk("R8", "reset err", err, 1'b0);
      chk("R8", "reset state_out", state_out, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_sbox_known();
      // zero key, last round: each output byte is a bare S-box value
      apply('0, '0, '0, '0, 1'b1);
      chk("R2", "sbox(00)", state_out, {16{8'h63}});
      chk("R4", "err clean", err, 1'b0);
      apply({16{8'h53}}, '0, '0, '0, 1'b1);
      chk("R2", "sbox(53)", state_out, {16{8'hed}});
   endtask

   task automatic t_clean(input logic last, input int n);
      for (int i = 0; i < n; i++) begin
         logic [127:0] s, key;
         s = rnd128(); key = rnd128();
         run_round(last ? "R2" : "R1", s, m_par(s), key, m_par(key), last);
         chk("R4", "clean err", err, 1'b0);
      end
   endtask

   task automatic t_state_par_err(input logic last, input int pos);
      logic [127:0] s, key;
      s = rnd128(); key = rnd128();
      run_round("R5", s, m_par(s) ^ (16'h8000 >> pos), key, m_par(key), last);
      chk("R5", "err", err, 1'b1);
      chk("R5", "mismatch count", 32'($countones(par_pred ^ par_gen)), last ? 1 : 3);
   endtask

   task automatic t_key_par_err(input int pos);
      logic [127:0] s, key;
      s = rnd128(); key = rnd128();
      run_round("R6", s, m_par(s), key, m_par(key) ^ (16'h8000 >> pos), 1'b0);
      chk("R6", "mismatch position", par_pred ^ par_gen, 16'h8000 >> pos);
      chk("R6", "err", err, 1'b1);
   endtask

   task automatic t_double_flip();
      logic [127:0] s, key, s2;
      s = rnd128(); key = rnd128();
      s2 = s ^ (128'h3 << 40);
      run_round("R7", s2, m_par(s), key, m_par(key), 1'b0);
      chk("R7", "double flip undetected", err, 1'b0);
      n_tests++;
      if (state_out === m_round(s, key, 1'b0)) begin
         n_fail++;
         $display("FAIL R7 output: actual %h expected a changed value", state_out);
      end
   endtask

   task automatic t_hold();
      logic [127:0] held;
      logic         held_err;
      logic [127:0] s, key;
      s = rnd128(); key = rnd128();
      run_round("R8", s, m_par(s) ^ 16'h0001, key, m_par(key), 1'b0);
      held = state_out; held_err = err;
      @(negedge clk);
      state_in = rnd128(); rkey_in = rnd128(); state_par_in = '0; rkey_par_in = '0;
      final_rnd = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8", "hold state_out", state_out, held);
      chk("R8", "hold err", err, held_err);
      chk("R8", "hold valid_out", valid_out, 1'b0);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sbox_known();
      t_clean(1'b0, 4);
      t_clean(1'b1, 3);
      t_state_par_err(1'b0, 0);
      t_state_par_err(1'b0, 6);
      t_state_par_err(1'b0, 13);
      t_state_par_err(1'b1, 5);
      t_state_par_err(1'b1, 15);
      t_key_par_err(2);
      t_key_par_err(11);
      t_double_flip();
      t_hold();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule